// File: doc/BRIEF.md
# Memory-Mapped GPIO Bank with Edge Capture

This block is a general-purpose I/O controller for a parameterised number of pins, always a multiple of 32. Software reaches it through a plain 32-bit register bus with a write strobe, a byte address and a data word. Reads are combinational from the address. Each pin has a direction bit, an output latch, independent rising and falling edge enables, a sticky edge status bit, and a two-bit alternate-function field. The output latch changes only through write-one set and write-one clear strobes, so one pin can be changed without touching the others.

Pad inputs pass through a two-flop synchroniser. An edge is detected by comparing the synchronised value with its value one cycle earlier. An enabled edge latches into the status bit, and every status bit feeds one combined interrupt line. Software clears status by writing ones. If a fresh edge arrives in the same cycle as that clear, the edge is kept. The block drives output enables, output values and alternate-function selects toward the pad ring.

Top module: `gpio_bank`

## Requirements
- R1: Registers are grouped by kind, each kind occupying N/32 consecutive words in this order: level, direction, set, clear, rising enable, falling enable, edge status, alternate function. The byte address is kind_index*(N/32)*4 + (pin/32)*4, and the pin sits at bit pin%32. The alternate-function kind holds 2*(N/32) words.
- R2: A direction bit of 1 makes the pin an output, and pad_oe[pin] equals that bit. The direction register reads back as written.
- R3: Writing a 1 to a bit of the set register drives pad_out[pin] high one cycle later. Zero bits leave outputs unchanged. Set and clear registers read as zero.
- R4: Writing a 1 to a bit of the clear register drives pad_out[pin] low one cycle later. Zero bits leave outputs unchanged.
- R5: The level register returns pad_in after the two-flop synchroniser. A pad change is visible in a read after two rising clock edges.
- R6: With its rising enable set, a 0-to-1 pad transition sets the pin's status bit on the third rising edge after the pad change. Without the enable, nothing is latched.
- R7: Rising and falling enables act independently. A falling enable alone catches only 1-to-0 transitions, and with both enables set either transition is caught.
- R8: Status bits are sticky. Writing 1 to a bit clears it, writing 0 leaves it, and writing all ones clears the whole word.
- R9: When an edge on a pin and a clearing write to its status bit take effect in the same cycle, the bit stays set.
- R10: irq is high exactly while at least one status bit is set. It stays high until the last set bit is cleared.
- R11: Alternate-function words hold 16 pins each, 2 bits per pin, at word pin/16 and bits (pin%16)*2. alt_sel[2*pin+1:2*pin] mirrors that field, and the fields read back as written.
- R12: Reset makes every pin an input, clears the output latches, enables, status and alternate fields, and leaves irq low. Reads of unmapped or unaligned addresses return zero, and writes to the level register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| pad_in | input | N_PINS | Asynchronous pad input levels |
| pad_oe | output | N_PINS | Per-pin output enable (1 = drive) |
| pad_out | output | N_PINS | Per-pin output value |
| alt_sel | output | 2*N_PINS | Per-pin alternate-function select, 2 bits each |
| irq | output | 1 | OR of all edge status bits |

## Verification
The collision that matters is an edge being latched into a status bit in the same cycle that software writes a one to clear that bit. The bench provokes it by raising a pad with its rising enable set. It waits the two synchroniser edges, then issues a status write whose commit edge is the one on which the edge latches. The write also clears a neighbouring bit that has no new edge. The pin with the fresh edge must read back set, and the neighbour must read back clear.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int WORD_W        = 32;
    localparam int PINS_PER_WORD = 32;
    localparam int ALT_PER_WORD  = 16;
    localparam int PLAIN_KINDS   = 7;
    localparam int IDX_W         = 8;

    // Order of kinds fixes the address map
    typedef enum logic [2:0] {
        K_LEVEL = 3'd0,
        K_DIR   = 3'd1,
        K_SET   = 3'd2,
        K_CLR   = 3'd3,
        K_RISE  = 3'd4,
        K_FALL  = 3'd5,
        K_STAT  = 3'd6,
        K_ALT   = 3'd7
    } reg_kind_e;

    typedef struct packed {
        logic              hit;
        reg_kind_e         kind;
        logic [IDX_W-1:0]  idx;
    } reg_sel_t;

    typedef struct packed {
        logic [WORD_W-1:0] rise;
        logic [WORD_W-1:0] fall;
    } edge_pair_t;

    // Map a word address onto (kind, index within kind)
    function automatic reg_sel_t decode_word(input int unsigned word,
                                             input int unsigned nw);
        reg_sel_t s;
        s = '0;
        if (word < PLAIN_KINDS * nw) begin
            s.hit  = 1'b1;
            s.kind = reg_kind_e'(3'(word / nw));
            s.idx  = IDX_W'(word % nw);
        end else if (word < (PLAIN_KINDS + 2) * nw) begin
            s.hit  = 1'b1;
            s.kind = K_ALT;
            s.idx  = IDX_W'(word - PLAIN_KINDS * nw);
        end
        return s;
    endfunction

    // Edge detection for one word of pins
    function automatic edge_pair_t find_edges(input logic [WORD_W-1:0] cur,
                                              input logic [WORD_W-1:0] prev);
        edge_pair_t e;
        e.rise = cur & ~prev;
        e.fall = ~cur & prev;
        return e;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_edge_word.sv
module gpio_edge_word
    import gpio_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] cur,
    input  logic [WORD_W-1:0] prev,
    input  logic [WORD_W-1:0] rise_en,
    input  logic [WORD_W-1:0] fall_en,
    input  logic [WORD_W-1:0] clr_mask,
    output logic [WORD_W-1:0] status
);
    edge_pair_t        ep;
    logic [WORD_W-1:0] caught;

    always_comb begin
        ep     = find_edges(cur, prev);
        caught = (ep.rise & rise_en) | (ep.fall & fall_en);
    end

    // A fresh edge overrides a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= (status & ~clr_mask) | caught;
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int N_PINS = 64,
    parameter int ADDR_W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [31:0]         wdata,
    output logic [31:0]         rdata,
    input  logic [N_PINS-1:0]   pad_in,
    output logic [N_PINS-1:0]   pad_oe,
    output logic [N_PINS-1:0]   pad_out,
    output logic [2*N_PINS-1:0] alt_sel,
    output logic                irq
);
    localparam int NW   = N_PINS / PINS_PER_WORD;
    localparam int NALT = N_PINS / ALT_PER_WORD;

    logic [N_PINS-1:0]          pad_sync, pad_prev;
    logic [NW-1:0][WORD_W-1:0]  lvl_words, prev_words;
    logic [NW-1:0][WORD_W-1:0]  dir_q, out_q, ren_q, fen_q, stat;
    logic [NALT-1:0][WORD_W-1:0] alt_q;
    logic [N_PINS-1:0]          stat_flat;
    reg_sel_t                   sel;
    logic                       aligned;
    logic                       wr_ok;

    gpio_sync #(.W(N_PINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pad_sync)
    );

    always_ff @(posedge clk) begin
        if (rst) pad_prev <= '0;
        else     pad_prev <= pad_sync;
    end

    assign lvl_words  = pad_sync;
    assign prev_words = pad_prev;

    always_comb begin
        aligned = (addr[1:0] == 2'b00);
        sel     = decode_word(int'(addr[ADDR_W-1:2]), NW);
        wr_ok   = wr_en && aligned && sel.hit;
    end

    for (genvar w = 0; w < NW; w++) begin : g_word
        logic wr_w;
        assign wr_w = wr_ok && (sel.idx == IDX_W'(w));

        always_ff @(posedge clk) begin
            if (rst) begin
                dir_q[w] <= '0;
                out_q[w] <= '0;
                ren_q[w] <= '0;
                fen_q[w] <= '0;
            end else if (wr_w) begin
                case (sel.kind)
                    K_DIR:   dir_q[w] <= wdata;
                    K_SET:   out_q[w] <= out_q[w] | wdata;
                    K_CLR:   out_q[w] <= out_q[w] & ~wdata;
                    K_RISE:  ren_q[w] <= wdata;
                    K_FALL:  fen_q[w] <= wdata;
                    default: ;
                endcase
            end
        end

        gpio_edge_word u_edge (
            .clk      (clk),
            .rst      (rst),
            .cur      (lvl_words[w]),
            .prev     (prev_words[w]),
            .rise_en  (ren_q[w]),
            .fall_en  (fen_q[w]),
            .clr_mask ((wr_w && sel.kind == K_STAT) ? wdata : '0),
            .status   (stat[w])
        );
    end

    for (genvar a = 0; a < NALT; a++) begin : g_alt
        always_ff @(posedge clk) begin
            if (rst)
                alt_q[a] <= '0;
            else if (wr_ok && sel.kind == K_ALT && sel.idx == IDX_W'(a))
                alt_q[a] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (aligned && sel.hit) begin
            for (int w = 0; w < NW; w++) begin
                if (sel.idx == IDX_W'(w)) begin
                    case (sel.kind)
                        K_LEVEL: rdata = lvl_words[w];
                        K_DIR:   rdata = dir_q[w];
                        K_RISE:  rdata = ren_q[w];
                        K_FALL:  rdata = fen_q[w];
                        K_STAT:  rdata = stat[w];
                        default: ;
                    endcase
                end
            end
            for (int a = 0; a < NALT; a++) begin
                if (sel.kind == K_ALT && sel.idx == IDX_W'(a))
                    rdata = alt_q[a];
            end
        end
    end

    assign stat_flat = stat;
    assign pad_oe    = dir_q;
    assign pad_out   = out_q;
    assign alt_sel   = alt_q;
    assign irq       = |stat_flat;
endmodule

// File: rtl/gpio_bank_checker.sv
module gpio_bank_checker #(
    parameter int N_PINS = 64,
    parameter int ADDR_W = 12
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [31:0]         wdata,
    input logic [31:0]         rdata,
    input logic [N_PINS-1:0]   pad_oe,
    input logic [N_PINS-1:0]   pad_out,
    input logic [2*N_PINS-1:0] alt_sel,
    input logic                irq,
    input logic [N_PINS-1:0]   stat_flat
);
    localparam int NW = N_PINS / 32;
    localparam logic [ADDR_W-1:0] SET0  = ADDR_W'(2 * NW * 4);
    localparam logic [ADDR_W-1:0] CLR0  = ADDR_W'(3 * NW * 4);
    localparam logic [ADDR_W-1:0] STAT0 = ADDR_W'(6 * NW * 4);
    localparam logic [ADDR_W-1:0] END_A = ADDR_W'(9 * NW * 4);

    logic [31:0] st0;
    assign st0 = stat_flat[31:0];

    AST_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == SET0) |=> ((pad_out[31:0] & $past(wdata)) == $past(wdata))); // R3
    AST_CLR_DRIVES_LOW: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == CLR0) |=> ((pad_out[31:0] & $past(wdata)) == 32'h0)); // R4
    AST_OE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(pad_oe)); // R2
    AST_ALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(alt_sel)); // R11
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == STAT0) |=> ((st0 & $past(st0)) == $past(st0))); // R8
    AST_IRQ_DROPS_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(wr_en)); // R10
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (addr >= END_A) |-> (rdata == 32'h0)); // R12
endmodule

bind gpio_bank gpio_bank_checker #(.N_PINS(N_PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .alt_sel   (alt_sel),
    .irq       (irq),
    .stat_flat (stat_flat)
);

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;
    localparam int N = 64;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [N-1:0]  pad_in = '0;
    logic [N-1:0]  pad_oe, pad_out;
    logic [2*N-1:0] alt_sel;
    logic          irq;

    int checks = 0;
    int fails  = 0;

    // Addresses for N=64: each kind spans 2 words
    localparam logic [AW-1:0] A_LVL0 = 12'h000, A_LVL1 = 12'h004;
    localparam logic [AW-1:0] A_DIR1 = 12'h00C, A_DIR0 = 12'h008;
    localparam logic [AW-1:0] A_SET0 = 12'h010, A_SET1 = 12'h014;
    localparam logic [AW-1:0] A_CLR0 = 12'h018;
    localparam logic [AW-1:0] A_RIS0 = 12'h020, A_RIS1 = 12'h024;
    localparam logic [AW-1:0] A_FAL1 = 12'h02C;
    localparam logic [AW-1:0] A_ST0  = 12'h030, A_ST1  = 12'h034;
    localparam logic [AW-1:0] A_ALT1 = 12'h03C, A_ALT3 = 12'h044;

    always #10 clk = ~clk;

    gpio_bank #(.N_PINS(N), .ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
        .alt_sel(alt_sel), .irq(irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R12 oe", 64'(pad_oe), 64'h0);
        chk("R12 out", 64'(pad_out), 64'h0);
        chk("R12 alt", 64'(alt_sel[63:0] | alt_sel[127:64]), 64'h0);
        chk("R12 irq", 64'(irq), 64'h0);
        rd(A_ST0, d); chk("R12 status", 64'(d), 64'h0);
    endtask

    task automatic t_dir();
        logic [31:0] d;
        wr(A_DIR1, 32'hA5A5_0000);
        chk("R2 oe word1", 64'(pad_oe), 64'hA5A5_0000_0000_0000);
        rd(A_DIR1, d); chk("R2 readback", 64'(d), 64'hA5A5_0000);
        rd(A_DIR0, d); chk("R1 dir word0", 64'(d), 64'h0);
    endtask

    task automatic t_setclr();
        logic [31:0] d;
        wr(A_SET0, 32'h0000_00F0); chk("R3 set", 64'(pad_out), 64'hF0);
        wr(A_SET0, 32'h0000_0001); chk("R3 zeros keep", 64'(pad_out), 64'hF1);
        wr(A_CLR0, 32'h0000_0030); chk("R4 clear", 64'(pad_out), 64'hC1);
        wr(A_SET1, 32'h8000_0000); chk("R1 set word1", 64'(pad_out), 64'h8000_0000_0000_00C1);
        rd(A_SET0, d); chk("R3 set reads 0", 64'(d), 64'h0);
        rd(A_CLR0, d); chk("R3 clr reads 0", 64'(d), 64'h0);
    endtask

    task automatic t_level();
        logic [31:0] d;
        pad_in = 64'h1234_5678_9ABC_DEF0;
        tick(1);
        rd(A_LVL0, d); chk("R5 one edge", 64'(d), 64'h0);
        tick(1);
        rd(A_LVL0, d); chk("R5 level0", 64'(d), 64'h9ABC_DEF0);
        rd(A_LVL1, d); chk("R5 level1", 64'(d), 64'h1234_5678);
        wr(A_LVL0, 32'hFFFF_FFFF);
        rd(A_LVL0, d); chk("R12 level write ignored", 64'(d), 64'h9ABC_DEF0);
        pad_in = '0;
        tick(4);
    endtask

    task automatic t_rise();
        logic [31:0] d;
        wr(A_RIS0, 32'h0000_0008);
        pad_in[3] = 1'b1;
        tick(2);
        rd(A_ST0, d); chk("R6 not yet", 64'(d), 64'h0);
        tick(1);
        rd(A_ST0, d); chk("R6 latched", 64'(d), 64'h8);
        chk("R10 irq up", 64'(irq), 64'h1);
        pad_in[3] = 1'b0;
        tick(4);
        rd(A_ST0, d); chk("R7 no fall enable", 64'(d), 64'h8);
        wr(A_ST0, 32'h0);
        rd(A_ST0, d); chk("R8 zero write keeps", 64'(d), 64'h8);
        wr(A_ST0, 32'hFFFF_FFFF);
        rd(A_ST0, d); chk("R8 all ones clears", 64'(d), 64'h0);
        chk("R10 irq down", 64'(irq), 64'h0);
    endtask

    task automatic t_fall_both();
        logic [31:0] d;
        wr(A_FAL1, 32'h0000_0003);
        wr(A_RIS1, 32'h0000_0002);
        pad_in[32] = 1'b1; tick(4);
        rd(A_ST1, d); chk("R7 rise ignored by fall-only", 64'(d), 64'h0);
        pad_in[32] = 1'b0; tick(4);
        rd(A_ST1, d); chk("R7 fall caught", 64'(d), 64'h1);
        pad_in[33] = 1'b1; tick(4);
        rd(A_ST1, d); chk("R7 both: rise", 64'(d), 64'h3);
        wr(A_ST1, 32'h2);
        rd(A_ST1, d); chk("R8 single clear", 64'(d), 64'h1);
        chk("R10 irq held", 64'(irq), 64'h1);
        pad_in[33] = 1'b0; tick(4);
        rd(A_ST1, d); chk("R7 both: fall", 64'(d), 64'h3);
        wr(A_ST1, 32'h1);
        chk("R10 irq still held", 64'(irq), 64'h1);
        wr(A_ST1, 32'h2);
        chk("R10 irq cleared", 64'(irq), 64'h0);
    endtask

    task automatic t_collide();
        logic [31:0] d;
        wr(A_RIS0, 32'h0000_0068);
        pad_in[5] = 1'b1; pad_in[6] = 1'b1; tick(4);
        rd(A_ST0, d); chk("R6 two pins", 64'(d), 64'h60);
        pad_in[5] = 1'b0; tick(4);
        pad_in[5] = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        wr(A_ST0, 32'h0000_0060);
        rd(A_ST0, d); chk("R9 edge beats clear", 64'(d), 64'h20);
        wr(A_ST0, 32'h0000_0020);
        rd(A_ST0, d); chk("R8 later clear", 64'(d), 64'h0);
    endtask

    task automatic t_alt();
        logic [31:0] d;
        wr(A_ALT1, 32'h0000_000C);
        chk("R11 pin17 field", 64'(alt_sel[35:34]), 64'h3);
        chk("R11 pin16 field", 64'(alt_sel[33:32]), 64'h0);
        wr(A_ALT3, 32'h8000_0000);
        chk("R11 pin63 field", 64'(alt_sel[127:126]), 64'h2);
        rd(A_ALT1, d); chk("R11 readback", 64'(d), 64'hC);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        rd(12'h048, d); chk("R12 past map", 64'(d), 64'h0);
        rd(12'h7FC, d); chk("R12 far address", 64'(d), 64'h0);
        rd(A_DIR1 + 12'h1, d); chk("R12 unaligned", 64'(d), 64'h0);
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        t_reset();
        t_dir();
        t_setclr();
        t_level();
        t_rise();
        t_fall_both();
        t_collide();
        t_alt();
        t_unmapped();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule